// File: doc/BRIEF.md
# Sensor Timing Configuration Bank

This block keeps the configuration word that steers a sensor's exposure and readout timing generator. The live word is presented as a flat parallel bus to downstream logic. Its contents come from one of two sources: a fixed typical image built into the logic, which lets the sensor run with no host involvement, or a staging register that the host fills one bit per clock over a serial pin. A single-cycle command copies the chosen source into the live word.

For confirmation, the host can take a snapshot of the live word into a separate readback shifter and clock it out serially, most significant bit first. Shifting new data into the staging register never disturbs the live word, so a new configuration can be staged while the old one is still in use. What the individual fields of the word mean is defined elsewhere.

Top module: `cfg_param_bank`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, the live word equals the default image, the readback valid output is 0 and the readback data output is 0.
- R2: The default image has bit i (i = 0 to 447) set to 1 exactly when one of "i is divisible by 3" and "i is divisible by 5" holds and the other does not.
- R3: Each clock with the shift enable high moves the staging register up one place and puts the serial input bit into bit 0, so that after exactly 448 shifts bit 447 holds the first bit received; shifting leaves the live word unchanged.
- R4: A parallel-load pulse makes the live word equal to the staging register contents after the next clock edge.
- R5: A default-load pulse, with no parallel-load pulse in the same cycle, makes the live word equal to the default image after the next clock edge.
- R6: When default-load and parallel-load are both high in one cycle, the staging contents are loaded and the default image is not.
- R7: A readback-start pulse captures the live word; after that edge the data output shows bit 447, and each further edge moves to the next lower bit, so bit j is shown for the cycle following edge number 447-j counted from the capture; valid is high for exactly those 448 cycles, and the data output is 0 whenever valid is low.
- R8: A readback-start pulse while a readback is still running discards the remaining bits and starts a fresh 448-bit readback of the current live word.
- R9: A parallel load in the same cycle as a shift loads the staging contents as they were before that shift.
- R10: A readback-start in the same cycle as a load captures the live word as it was before that load.
- R11: With both load commands low, the live word keeps its value from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_dflt_i | input | 1 | One-cycle command: copy default image to the live word |
| load_stage_i | input | 1 | One-cycle command: copy staging register to the live word |
| shift_en_i | input | 1 | Shift one serial bit into the staging register this cycle |
| shift_din_i | input | 1 | Serial configuration data in |
| rdbk_start_i | input | 1 | One-cycle command: snapshot live word and start serial readback |
| rdbk_dout_o | output | 1 | Serial readback data, most significant bit first |
| rdbk_valid_o | output | 1 | High while a readback bit is on rdbk_dout_o |
| cfg_word_o | output | 448 | Live configuration word to the timing generator |

## Verification
The assertions assume that the command inputs are driven to known levels from the release of reset onward and that they change only between clock edges; they make no assumption that commands are mutually exclusive, since the priority and same-cycle orderings are part of the block's defined behaviour. The stimulus is driven on the falling edge, keeps every input at 0 during reset, and deliberately overlaps load, shift and readback commands in the same cycle to reach the orderings named in R6, R9 and R10, and restarts a readback midway to reach R8.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

  localparam int unsigned CFG_W_DEFAULT = 448;

  typedef enum logic [1:0] {
    SRC_HOLD   = 2'd0,
    SRC_DFLT   = 2'd1,
    SRC_STAGE  = 2'd2
  } live_src_e;

  // Built-in image: set where exactly one of the two divisibility tests holds.
  function automatic logic dflt_bit(input int unsigned idx);
    logic by3;
    logic by5;
    by3 = ((idx % 3) == 0);
    by5 = ((idx % 5) == 0);
    return by3 ^ by5;
  endfunction

  // Staging copy takes priority over the default image.
  function automatic live_src_e pick_src(input logic want_dflt,
                                         input logic want_stage);
    live_src_e s;
    if (want_stage)     s = SRC_STAGE;
    else if (want_dflt) s = SRC_DFLT;
    else                s = SRC_HOLD;
    return s;
  endfunction

endpackage

// File: rtl/cfg_dflt_image.sv
module cfg_dflt_image #(
  parameter int unsigned W = cfgbank_pkg::CFG_W_DEFAULT
) (
  output logic [W-1:0] image_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    assign image_o[g] = cfgbank_pkg::dflt_bit(g);
  end
endmodule

// File: rtl/cfg_stage_sr.sv
module cfg_stage_sr #(
  parameter int unsigned W = cfgbank_pkg::CFG_W_DEFAULT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en_i,
  input  logic         din_i,
  output logic [W-1:0] stage_o
);
  logic [W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else if (shift_en_i) begin
      stage_q <= {stage_q[W-2:0], din_i};
    end
  end

  assign stage_o = stage_q;
endmodule

// File: rtl/cfg_live_reg.sv
module cfg_live_reg #(
  parameter int unsigned W = cfgbank_pkg::CFG_W_DEFAULT
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  cfgbank_pkg::live_src_e src_i,
  input  logic [W-1:0]           dflt_i,
  input  logic [W-1:0]           stage_i,
  output logic [W-1:0]           word_o
);
  import cfgbank_pkg::*;

  logic [W-1:0] word_q;
  logic [W-1:0] word_d;

  always_comb begin
    unique case (src_i)
      SRC_STAGE: word_d = stage_i;
      SRC_DFLT:  word_d = dflt_i;
      default:   word_d = word_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= dflt_i;
    else        word_q <= word_d;
  end

  assign word_o = word_q;
endmodule

// File: rtl/cfg_rdbk_sr.sv
module cfg_rdbk_sr #(
  parameter int unsigned W = cfgbank_pkg::CFG_W_DEFAULT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] word_i,
  output logic         dout_o,
  output logic         valid_o
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  snap_q;
  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      left_q <= '0;
    end else if (start_i) begin
      snap_q <= word_i;
      left_q <= CW'(W);
    end else if (left_q != '0) begin
      snap_q <= {snap_q[W-2:0], 1'b0};
      left_q <= left_q - CW'(1);
    end
  end

  assign valid_o = (left_q != '0);
  assign dout_o  = valid_o & snap_q[W-1];
endmodule

// File: rtl/cfg_param_bank.sv
module cfg_param_bank #(
  parameter int unsigned W = cfgbank_pkg::CFG_W_DEFAULT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_dflt_i,
  input  logic         load_stage_i,
  input  logic         shift_en_i,
  input  logic         shift_din_i,
  input  logic         rdbk_start_i,
  output logic         rdbk_dout_o,
  output logic         rdbk_valid_o,
  output logic [W-1:0] cfg_word_o
);
  import cfgbank_pkg::*;

  logic [W-1:0] dflt_img;
  logic [W-1:0] stage_q;
  live_src_e    live_src;
  logic         take_stage;
  logic         take_dflt;

  assign live_src   = pick_src(load_dflt_i, load_stage_i);
  assign take_stage = (live_src == SRC_STAGE);
  assign take_dflt  = (live_src == SRC_DFLT);

  cfg_dflt_image #(.W(W)) u_dflt (
    .image_o (dflt_img)
  );

  cfg_stage_sr #(.W(W)) u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_en_i (shift_en_i),
    .din_i      (shift_din_i),
    .stage_o    (stage_q)
  );

  cfg_live_reg #(.W(W)) u_live (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_i   (live_src),
    .dflt_i  (dflt_img),
    .stage_i (stage_q),
    .word_o  (cfg_word_o)
  );

  cfg_rdbk_sr #(.W(W)) u_rdbk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (rdbk_start_i),
    .word_i  (cfg_word_o),
    .dout_o  (rdbk_dout_o),
    .valid_o (rdbk_valid_o)
  );
endmodule

// File: rtl/cfg_param_bank_chk.sv
module cfg_param_bank_chk #(
  parameter int unsigned W = cfgbank_pkg::CFG_W_DEFAULT
) (
  input logic         clk,
  input logic         rst_n,
  input logic         load_dflt_i,
  input logic         load_stage_i,
  input logic         shift_en_i,
  input logic         shift_din_i,
  input logic         rdbk_start_i,
  input logic         rdbk_dout_o,
  input logic         rdbk_valid_o,
  input logic [W-1:0] cfg_word_o,
  input logic [W-1:0] stage_q,
  input logic [W-1:0] dflt_img,
  input logic         take_stage,
  input logic         take_dflt
);
  p_reset_default_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cfg_word_o == dflt_img) && !rdbk_valid_o);

  p_shift_lsb_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en_i |=> (stage_q[0] == $past(shift_din_i)));

  p_stage_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_stage_i |=> (cfg_word_o == $past(stage_q)));

  p_dflt_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_dflt_i && !load_stage_i) |=> (cfg_word_o == dflt_img));

  p_stage_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_dflt_i && load_stage_i) |-> (take_stage && !take_dflt));

  p_rdbk_first_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rdbk_start_i |=> rdbk_valid_o && (rdbk_dout_o == $past(cfg_word_o[W-1])));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rdbk_valid_o |-> !rdbk_dout_o);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_dflt_i && !load_stage_i) |=> $stable(cfg_word_o));
endmodule

bind cfg_param_bank cfg_param_bank_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .load_dflt_i  (load_dflt_i),
  .load_stage_i (load_stage_i),
  .shift_en_i   (shift_en_i),
  .shift_din_i  (shift_din_i),
  .rdbk_start_i (rdbk_start_i),
  .rdbk_dout_o  (rdbk_dout_o),
  .rdbk_valid_o (rdbk_valid_o),
  .cfg_word_o   (cfg_word_o),
  .stage_q      (stage_q),
  .dflt_img     (dflt_img),
  .take_stage   (take_stage),
  .take_dflt    (take_dflt)
);

// File: tb/sim_cfg_param_bank.sv
module sim_cfg_param_bank;
  localparam int W = 448;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_dflt_i = 1'b0;
  logic         load_stage_i = 1'b0;
  logic         shift_en_i = 1'b0;
  logic         shift_din_i = 1'b0;
  logic         rdbk_start_i = 1'b0;
  logic         rdbk_dout_o;
  logic         rdbk_valid_o;
  logic [W-1:0] cfg_word_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 0;
  string tag  = "R1";

  logic [W-1:0] m_work;
  logic [W-1:0] m_stage;
  logic [W-1:0] ref_dflt;
  bit           rb_q[$];
  logic [31:0]  pat = 32'h1234_5678;
  bit           first_bit;

  always #4 clk = ~clk;

  cfg_param_bank #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .load_dflt_i(load_dflt_i),
    .load_stage_i(load_stage_i), .shift_en_i(shift_en_i),
    .shift_din_i(shift_din_i), .rdbk_start_i(rdbk_start_i),
    .rdbk_dout_o(rdbk_dout_o), .rdbk_valid_o(rdbk_valid_o),
    .cfg_word_o(cfg_word_o)
  );

  function automatic bit next_bit();
    pat = pat * 32'd1103515245 + 32'd12345;
    return pat[16];
  endfunction

  task automatic chk(input string rq, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // Drive one cycle at a falling edge, advance the model, compare after the edge.
  task automatic step(input bit ld, input bit ls, input bit se, input bit sd, input bit rs);
    load_dflt_i  = ld;
    load_stage_i = ls;
    shift_en_i   = se;
    shift_din_i  = sd;
    rdbk_start_i = rs;
    if (rs) begin
      rb_q.delete();
      for (int i = W - 1; i >= 0; i--) rb_q.push_back(m_work[i]);
    end else if (rb_q.size() > 0) begin
      void'(rb_q.pop_front());
    end
    if (ls)      m_work = m_stage;
    else if (ld) m_work = ref_dflt;
    if (se)      m_stage = {m_stage[W-2:0], sd};
    @(negedge clk);
    chk({tag, " word"}, cfg_word_o, m_work);
    chk({tag, " valid"}, W'(rdbk_valid_o), W'(rb_q.size() > 0));
    chk({tag, " dout"}, W'(rdbk_dout_o), W'((rb_q.size() > 0) ? rb_q[0] : 1'b0));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  task automatic shift_in(input int n);
    for (int i = 0; i < n; i++) begin
      bit b;
      b = next_bit();
      if (i == 0) first_bit = b;
      step(0, 0, 1, b, 0);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    // R2: default image restated with running remainders.
    begin
      int c3 = 0;
      int c5 = 0;
      for (int i = 0; i < W; i++) begin
        ref_dflt[i] = (c3 == 0) != (c5 == 0);
        c3 = (c3 == 2) ? 0 : c3 + 1;
        c5 = (c5 == 4) ? 0 : c5 + 1;
      end
    end
    m_work  = ref_dflt;
    m_stage = '0;

    repeat (3) @(negedge clk);
    tag = "R1";
    chk("R1 word in reset", cfg_word_o, ref_dflt);
    chk("R1 valid in reset", W'(rdbk_valid_o), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 word after reset", cfg_word_o, ref_dflt);
    chk("R1 dout after reset", W'(rdbk_dout_o), '0);
    chk("R2 bit0", W'(cfg_word_o[0]), W'(1'b0));
    chk("R2 bit3", W'(cfg_word_o[3]), W'(1'b1));
    chk("R2 bit5", W'(cfg_word_o[5]), W'(1'b1));
    chk("R2 bit15", W'(cfg_word_o[15]), W'(1'b0));
    idle(2);

    tag = "R3";
    shift_in(W);
    chk("R3 live word untouched by shifting", cfg_word_o, ref_dflt);

    tag = "R4";
    step(0, 1, 0, 0, 0);
    chk("R3 first bit lands in 447", W'(cfg_word_o[W-1]), W'(first_bit));
    chk("R11 after load", cfg_word_o, m_work);
    idle(3);

    tag = "R7";
    step(0, 0, 0, 0, 1);
    idle(W + 4);

    tag = "R5";
    step(1, 0, 0, 0, 0);
    chk("R5 default reloaded", cfg_word_o, ref_dflt);
    idle(2);

    tag = "R6";
    shift_in(W);
    step(1, 1, 0, 0, 0);
    chk("R6 stage wins over default", cfg_word_o, m_stage);
    idle(2);

    tag = "R9";
    shift_in(37);
    step(0, 1, 1, 1, 0);
    shift_in(5);
    step(0, 1, 0, 0, 0);

    tag = "R8";
    step(0, 0, 0, 0, 1);
    idle(100);
    step(1, 0, 0, 0, 1);
    idle(60);

    tag = "R10";
    step(0, 1, 0, 0, 1);
    idle(W + 2);

    tag = "R11";
    idle(5);
    finish_run();
  end
endmodule